// File: doc/BRIEF.md
# Thermal Throttle Voltage-Frequency Sequencer

This block is the control half of an on-die thermal protection loop. It watches a single over-temperature flag and, while that flag is high, pulls the core back to a safer operating point. Two throttling methods exist. In the preferred one the sequencer first drops the bus ratio to a programmed low value. It then lowers the supply by walking the 6-bit voltage code one code at a time toward a target code. When the flag clears, it walks the code back to nominal and raises the ratio again only after the voltage has been restored. The second method gates the core clock on and off at a fixed duty cycle. It is used when the voltage-frequency method is disabled.

Regulator settling and clock-generator relock are not modelled as analog behaviour. They appear as two programmable hold counts. The sequencer waits the ratio hold after every ratio change and the voltage hold after every code step before it takes its next action. Voltage codes use the usual inverted encoding: a larger code is a lower voltage, and one code is a 12.5 mV step.

States: `ST_IDLE` (nominal point; outputs follow the nominal inputs), `ST_RATIO_DN_HOLD` (ratio lowered, waiting), `ST_VID_DN_HOLD` (one code stepped down in voltage, waiting), `ST_LOW_HOLD` (at target, waiting for the flag to clear), `ST_VID_UP_HOLD` (one code stepped up in voltage, waiting), `ST_RATIO_UP_HOLD` (ratio restored, waiting), `ST_CLK_MOD` (clock gating).

Transitions:
- IDLE→RATIO_DN_HOLD when hot with the voltage-frequency mode enabled.
- IDLE→CLK_MOD when hot with only clock gating enabled.
- RATIO_DN_HOLD or VID_DN_HOLD at the end of the hold: →VID_DN_HOLD if still hot and the code is short of the target, →LOW_HOLD if the code is at the target, or the ascent if the flag has cleared.
- LOW_HOLD→ascent when the flag clears.
- VID_UP_HOLD at the end of the hold→ascent.
- The ascent goes to VID_UP_HOLD while the code differs from nominal, otherwise to RATIO_UP_HOLD.
- RATIO_UP_HOLD at the end of the hold→IDLE.
- CLK_MOD→IDLE when the flag clears.

Top module: `thermal_vf_seq`

## Requirements
- R1: Out of reset and while idle, `ratio_o` equals `ratio_nom_i`, `vid_o` equals `vid_nom_i`, `core_clk_en_o` is 1 and `throttle_o` is 0. The ratio and code outputs follow changes of the nominal inputs in the same cycle.
- R2: With `vfstep_en_i`=1, the first clock edge that sees `hot_i`=1 in idle sets `ratio_o` to `ratio_tgt_i` and raises `throttle_o`. At that point `vid_o` is still the nominal code. The code only moves while the ratio is at its target value.
- R3: After the ratio drop the code holds for RATIO_HOLD cycles. It then moves by exactly one code (12.5 mV) toward `vid_tgt_i` once every VID_HOLD cycles and stops at the target.
- R4: While throttling, `vid_o` never leaves the closed range between `vid_nom_i` and `vid_tgt_i`. When the two codes are equal, the code never moves.
- R5: When `hot_i` clears, the code walks back toward `vid_nom_i` one code per VID_HOLD cycles. `ratio_o` returns to `ratio_nom_i` only VID_HOLD cycles after the code has reached nominal.
- R6: If `hot_i` clears partway through the descent, the next action is a one-code step back toward nominal from the current code. No further descent occurs.
- R7: `throttle_o` stays 1 from the ratio drop until RATIO_HOLD cycles after the ratio restore, and then falls to 0.
- R8: With `vfstep_en_i`=0 and `clkmod_en_i`=1, a hot flag starts clock gating. In each MOD_PERIOD-cycle window `core_clk_en_o` is 0 for the first MOD_OFF cycles and 1 for the rest, starting in the cycle after the flag is seen. Ratio and code stay nominal and `throttle_o` is 1.
- R9: In clock gating, the first edge that sees `hot_i`=0 returns the block to idle, with `core_clk_en_o`=1 and `throttle_o`=0.
- R10: With both enables at 0, `hot_i` has no effect: all outputs keep their idle values.
- R11: The enables are sampled only on entry. Changing them during a voltage-frequency walk does not gate the clock and does not stop the walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hot_i | input | 1 | Over-temperature flag |
| vfstep_en_i | input | 1 | Enables the ratio and voltage-code method |
| clkmod_en_i | input | 1 | Enables the clock-gating method |
| ratio_nom_i | input | RATIO_W | Nominal bus ratio |
| ratio_tgt_i | input | RATIO_W | Throttled bus ratio |
| vid_nom_i | input | VID_W | Nominal voltage code |
| vid_tgt_i | input | VID_W | Throttled voltage code (larger code is lower voltage) |
| core_clk_en_o | output | 1 | Core clock enable |
| ratio_o | output | RATIO_W | Current bus ratio |
| vid_o | output | VID_W | Current voltage code |
| throttle_o | output | 1 | Throttling active |

## Verification
The checker watches the ordering rules on every cycle:
- the code stays inside its clamp range;
- the code never jumps more than one code;
- the code moves only while the ratio is lowered;
- a ratio change during throttling happens only at the nominal code;
- the spacing between consecutive actions is at least the hold that applies to the previous action;
- clock gating never happens outside throttling or away from the nominal point.

The directed scenarios show what the assertions cannot see from a single cycle:
- the exact cycles at which each step lands;
- the reversal point when the flag clears mid-descent;
- the duty-cycle pattern of clock gating;
- that disabled or changed enables leave the outputs alone.

// File: rtl/thermal_seq_pkg.sv
package thermal_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RATIO_DN_HOLD,
        ST_VID_DN_HOLD,
        ST_LOW_HOLD,
        ST_VID_UP_HOLD,
        ST_RATIO_UP_HOLD,
        ST_CLK_MOD
    } tseq_state_e;

    typedef enum logic [1:0] {
        VOP_HOLD,
        VOP_LOAD_NOM,
        VOP_TO_TGT,
        VOP_TO_NOM
    } vid_op_e;

endpackage

// File: rtl/tseq_hold_timer.sv
module tseq_hold_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] value_i,
    output logic             done_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= value_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done_o = (cnt_q == '0);
endmodule

// File: rtl/tseq_vid_stepper.sv
module tseq_vid_stepper
    import thermal_seq_pkg::*;
#(
    parameter int VID_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  vid_op_e          op_i,
    input  logic [VID_W-1:0] nom_i,
    input  logic [VID_W-1:0] tgt_i,
    output logic [VID_W-1:0] code_o,
    output logic             at_nom_o,
    output logic             at_tgt_o
);
    logic [VID_W-1:0] code_q;
    logic [VID_W-1:0] moved;
    logic [VID_W-1:0] code_d;
    logic [VID_W-1:0] lo_bound;
    logic [VID_W-1:0] hi_bound;
    logic [VID_W-1:0] goal;

    assign lo_bound = (nom_i < tgt_i) ? nom_i : tgt_i;
    assign hi_bound = (nom_i < tgt_i) ? tgt_i : nom_i;
    assign goal     = (op_i == VOP_TO_TGT) ? tgt_i : nom_i;

    // one code per step toward the chosen end point
    always_comb begin
        if (code_q < goal) begin
            moved = code_q + 1'b1;
        end else if (code_q > goal) begin
            moved = code_q - 1'b1;
        end else begin
            moved = code_q;
        end
    end

    always_comb begin
        unique case (op_i)
            VOP_LOAD_NOM:           code_d = nom_i;
            VOP_TO_TGT, VOP_TO_NOM: code_d = moved;
            default:                code_d = code_q;
        endcase
        if (code_d < lo_bound) begin
            code_d = lo_bound;
        end else if (code_d > hi_bound) begin
            code_d = hi_bound;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
        end else begin
            code_q <= code_d;
        end
    end

    assign code_o   = code_q;
    assign at_nom_o = (code_q == nom_i);
    assign at_tgt_o = (code_q == tgt_i);
endmodule

// File: rtl/tseq_duty_gate.sv
module tseq_duty_gate #(
    parameter int PERIOD = 10,
    parameter int OFF    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic clk_en_o
);
    localparam int PH_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [PH_W-1:0] LAST = PH_W'(PERIOD - 1);
    localparam logic [PH_W-1:0] OFF_L = PH_W'(OFF);

    logic [PH_W-1:0] phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (!run_i) begin
            phase_q <= '0;
        end else if (phase_q == LAST) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    assign clk_en_o = !run_i || (phase_q >= OFF_L);
endmodule

// File: rtl/thermal_vf_seq.sv
module thermal_vf_seq
    import thermal_seq_pkg::*;
#(
    parameter int RATIO_W    = 5,
    parameter int VID_W      = 6,
    parameter int CNT_W      = 8,
    parameter int RATIO_HOLD = 4,
    parameter int VID_HOLD   = 3,
    parameter int MOD_PERIOD = 10,
    parameter int MOD_OFF    = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hot_i,
    input  logic               vfstep_en_i,
    input  logic               clkmod_en_i,
    input  logic [RATIO_W-1:0] ratio_nom_i,
    input  logic [RATIO_W-1:0] ratio_tgt_i,
    input  logic [VID_W-1:0]   vid_nom_i,
    input  logic [VID_W-1:0]   vid_tgt_i,
    output logic               core_clk_en_o,
    output logic [RATIO_W-1:0] ratio_o,
    output logic [VID_W-1:0]   vid_o,
    output logic               throttle_o
);
    localparam logic [CNT_W-1:0] RATIO_WAIT = CNT_W'(RATIO_HOLD - 1);
    localparam logic [CNT_W-1:0] VID_WAIT   = CNT_W'(VID_HOLD - 1);

    tseq_state_e        state_q, state_d;
    logic [RATIO_W-1:0] ratio_q, ratio_d;
    logic               tmr_load;
    logic [CNT_W-1:0]   tmr_val;
    logic               tmr_done;
    vid_op_e            vid_op;
    logic [VID_W-1:0]   vid_code;
    logic               vid_at_nom;
    logic               vid_at_tgt;
    logic               mod_run;
    logic               mod_clk_en;
    logic               at_nominal;

    // ascent action shared by several states
    tseq_state_e        asc_state;
    vid_op_e            asc_op;
    logic [RATIO_W-1:0] asc_ratio;
    logic [CNT_W-1:0]   asc_wait;

    tseq_hold_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (tmr_load),
        .value_i (tmr_val),
        .done_o  (tmr_done)
    );

    tseq_vid_stepper #(.VID_W(VID_W)) u_vid (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_i     (vid_op),
        .nom_i    (vid_nom_i),
        .tgt_i    (vid_tgt_i),
        .code_o   (vid_code),
        .at_nom_o (vid_at_nom),
        .at_tgt_o (vid_at_tgt)
    );

    tseq_duty_gate #(.PERIOD(MOD_PERIOD), .OFF(MOD_OFF)) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (mod_run),
        .clk_en_o (mod_clk_en)
    );

    always_comb begin
        if (!vid_at_nom) begin
            asc_state = ST_VID_UP_HOLD;
            asc_op    = VOP_TO_NOM;
            asc_ratio = ratio_q;
            asc_wait  = VID_WAIT;
        end else begin
            asc_state = ST_RATIO_UP_HOLD;
            asc_op    = VOP_HOLD;
            asc_ratio = ratio_nom_i;
            asc_wait  = RATIO_WAIT;
        end
    end

    // next-state and datapath control
    always_comb begin
        state_d  = state_q;
        ratio_d  = ratio_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        vid_op   = VOP_HOLD;
        unique case (state_q)
            ST_IDLE: begin
                vid_op  = VOP_LOAD_NOM;
                ratio_d = ratio_nom_i;
                if (hot_i && vfstep_en_i) begin
                    ratio_d  = ratio_tgt_i;
                    tmr_load = 1'b1;
                    tmr_val  = RATIO_WAIT;
                    state_d  = ST_RATIO_DN_HOLD;
                end else if (hot_i && clkmod_en_i) begin
                    state_d = ST_CLK_MOD;
                end
            end
            ST_RATIO_DN_HOLD, ST_VID_DN_HOLD: begin
                if (tmr_done) begin
                    if (!hot_i) begin
                        state_d  = asc_state;
                        vid_op   = asc_op;
                        ratio_d  = asc_ratio;
                        tmr_load = 1'b1;
                        tmr_val  = asc_wait;
                    end else if (!vid_at_tgt) begin
                        state_d  = ST_VID_DN_HOLD;
                        vid_op   = VOP_TO_TGT;
                        tmr_load = 1'b1;
                        tmr_val  = VID_WAIT;
                    end else begin
                        state_d = ST_LOW_HOLD;
                    end
                end
            end
            ST_LOW_HOLD: begin
                if (!hot_i) begin
                    state_d  = asc_state;
                    vid_op   = asc_op;
                    ratio_d  = asc_ratio;
                    tmr_load = 1'b1;
                    tmr_val  = asc_wait;
                end
            end
            ST_VID_UP_HOLD: begin
                if (tmr_done) begin
                    state_d  = asc_state;
                    vid_op   = asc_op;
                    ratio_d  = asc_ratio;
                    tmr_load = 1'b1;
                    tmr_val  = asc_wait;
                end
            end
            ST_RATIO_UP_HOLD: begin
                if (tmr_done) begin
                    state_d = ST_IDLE;
                end
            end
            ST_CLK_MOD: begin
                if (!hot_i) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ratio_q <= '0;
        end else begin
            state_q <= state_d;
            ratio_q <= ratio_d;
        end
    end

    // outputs
    always_comb begin
        at_nominal    = (state_q == ST_IDLE) || (state_q == ST_CLK_MOD);
        mod_run       = (state_q == ST_CLK_MOD);
        throttle_o    = (state_q != ST_IDLE);
        core_clk_en_o = mod_clk_en;
        ratio_o       = at_nominal ? ratio_nom_i : ratio_q;
        vid_o         = at_nominal ? vid_nom_i : vid_code;
    end
endmodule

// File: rtl/thermal_vf_seq_chk.sv
module thermal_vf_seq_chk #(
    parameter int RATIO_W    = 5,
    parameter int VID_W      = 6,
    parameter int CNT_W      = 8,
    parameter int RATIO_HOLD = 4,
    parameter int VID_HOLD   = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic [RATIO_W-1:0] ratio_nom_i,
    input logic [RATIO_W-1:0] ratio_tgt_i,
    input logic [VID_W-1:0]   vid_nom_i,
    input logic [VID_W-1:0]   vid_tgt_i,
    input logic               core_clk_en_o,
    input logic [RATIO_W-1:0] ratio_o,
    input logic [VID_W-1:0]   vid_o,
    input logic               throttle_o
);
    logic [VID_W-1:0]   lo_code, hi_code;
    logic [RATIO_W-1:0] prev_ratio;
    logic [VID_W-1:0]   prev_vid;
    logic               prev_thr;
    logic [CNT_W-1:0]   gap_q;
    logic               last_ratio_q;
    logic               act_rose, act_ratio, act_vid, act_now;
    int                 need;
    int                 vid_delta;

    assign lo_code   = (vid_nom_i < vid_tgt_i) ? vid_nom_i : vid_tgt_i;
    assign hi_code   = (vid_nom_i < vid_tgt_i) ? vid_tgt_i : vid_nom_i;
    assign act_rose  = throttle_o && !prev_thr;
    assign act_ratio = throttle_o && prev_thr && (ratio_o != prev_ratio);
    assign act_vid   = throttle_o && prev_thr && (vid_o != prev_vid);
    assign act_now   = act_rose || act_ratio || act_vid;
    assign need      = last_ratio_q ? RATIO_HOLD : VID_HOLD;
    assign vid_delta = int'(vid_o) - int'(prev_vid);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_ratio   <= '0;
            prev_vid     <= '0;
            prev_thr     <= 1'b0;
            gap_q        <= '1;
            last_ratio_q <= 1'b1;
        end else begin
            prev_ratio <= ratio_o;
            prev_vid   <= vid_o;
            prev_thr   <= throttle_o;
            if (act_now) begin
                gap_q        <= CNT_W'(1);
                last_ratio_q <= act_rose || act_ratio;
            end else if (gap_q != '1) begin
                gap_q <= gap_q + 1'b1;
            end
        end
    end

    assert_vid_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        throttle_o |-> (vid_o >= lo_code && vid_o <= hi_code));

    assert_vid_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        act_vid |-> (vid_delta == 1 || vid_delta == -1));

    assert_hold_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        act_now |-> (int'(gap_q) >= need));

    assert_vid_moves_at_low_ratio_R2: assert property (@(posedge clk) disable iff (!rst_n)
        act_vid |-> (ratio_o == ratio_tgt_i));

    assert_ratio_up_after_vid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        act_ratio |-> (vid_o == vid_nom_i));

    assert_gate_only_nominal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !core_clk_en_o |-> (throttle_o && ratio_o == ratio_nom_i && vid_o == vid_nom_i));

    assert_idle_clock_on_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!throttle_o && !$past(throttle_o)) |-> core_clk_en_o);
endmodule

bind thermal_vf_seq thermal_vf_seq_chk #(
    .RATIO_W    (RATIO_W),
    .VID_W      (VID_W),
    .CNT_W      (CNT_W),
    .RATIO_HOLD (RATIO_HOLD),
    .VID_HOLD   (VID_HOLD)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ratio_nom_i   (ratio_nom_i),
    .ratio_tgt_i   (ratio_tgt_i),
    .vid_nom_i     (vid_nom_i),
    .vid_tgt_i     (vid_tgt_i),
    .core_clk_en_o (core_clk_en_o),
    .ratio_o       (ratio_o),
    .vid_o         (vid_o),
    .throttle_o    (throttle_o)
);

// File: tb/tb_thermal_vf_seq.sv
module tb_thermal_vf_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hot = 1'b0;
    logic       vf_en = 1'b1;
    logic       mod_en = 1'b1;
    logic [4:0] r_nom = 5'd9;
    logic [4:0] r_tgt = 5'd6;
    logic [5:0] v_nom = 6'd16;
    logic [5:0] v_tgt = 6'd20;
    logic       clk_en;
    logic [4:0] ratio;
    logic [5:0] vid;
    logic       thr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    thermal_vf_seq dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .hot_i         (hot),
        .vfstep_en_i   (vf_en),
        .clkmod_en_i   (mod_en),
        .ratio_nom_i   (r_nom),
        .ratio_tgt_i   (r_tgt),
        .vid_nom_i     (v_nom),
        .vid_tgt_i     (v_tgt),
        .core_clk_en_o (clk_en),
        .ratio_o       (ratio),
        .vid_o         (vid),
        .throttle_o    (thr)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1", "ratio after reset", ratio, 9);
        chk("R1", "vid after reset", vid, 16);
        chk("R1", "clk_en after reset", clk_en, 1);
        chk("R1", "throttle after reset", thr, 0);
        r_nom = 5'd11;
        #1;
        chk("R1", "ratio follows nominal", ratio, 11);
        r_nom = 5'd9;
        tick(2);
    endtask

    task automatic t_vf_full;
        hot = 1'b1;
        tick(1);
        chk("R2", "ratio dropped", ratio, 6);
        chk("R2", "throttle raised", thr, 1);
        chk("R2", "vid still nominal", vid, 16);
        tick(3);
        chk("R3", "vid held during ratio hold", vid, 16);
        tick(1);
        chk("R3", "first step", vid, 17);
        chk("R11", "clock not gated in walk", clk_en, 1);
        tick(3);
        chk("R3", "second step", vid, 18);
        tick(3);
        chk("R3", "third step", vid, 19);
        tick(3);
        chk("R3", "reached target", vid, 20);
        tick(6);
        chk("R3", "stops at target", vid, 20);
        chk("R3", "ratio stays low", ratio, 6);
        hot = 1'b0;
        tick(1);
        chk("R5", "first up step", vid, 19);
        tick(3);
        chk("R5", "up step", vid, 18);
        tick(3);
        chk("R5", "up step", vid, 17);
        tick(3);
        chk("R5", "back at nominal", vid, 16);
        chk("R5", "ratio still low at nominal code", ratio, 6);
        tick(2);
        chk("R5", "ratio waits vid hold", ratio, 6);
        tick(1);
        chk("R5", "ratio restored", ratio, 9);
        chk("R7", "throttle held at restore", thr, 1);
        tick(3);
        chk("R7", "throttle held during hold", thr, 1);
        tick(1);
        chk("R7", "throttle released", thr, 0);
        tick(2);
    endtask

    task automatic t_reverse;
        hot = 1'b1;
        tick(1);
        chk("R6", "entry", ratio, 6);
        tick(4);
        chk("R6", "step to 17", vid, 17);
        tick(3);
        chk("R6", "step to 18", vid, 18);
        hot = 1'b0;
        tick(2);
        chk("R6", "hold not cut short", vid, 18);
        tick(1);
        chk("R6", "reversed from current code", vid, 17);
        tick(3);
        chk("R6", "nominal code", vid, 16);
        tick(3);
        chk("R6", "ratio restored", ratio, 9);
        tick(4);
        chk("R7", "idle after reversal", thr, 0);
        tick(2);
    endtask

    task automatic t_clamp;
        v_tgt = 6'd16;
        hot = 1'b1;
        tick(1);
        chk("R4", "ratio dropped", ratio, 6);
        for (int i = 0; i < 10; i++) begin
            tick(1);
            if (vid != 6'd16) chk("R4", "vid moved with equal codes", vid, 16);
        end
        chk("R4", "vid fixed at equal codes", vid, 16);
        chk("R4", "still throttling", thr, 1);
        hot = 1'b0;
        tick(1);
        chk("R4", "ratio restored directly", ratio, 9);
        tick(4);
        chk("R7", "idle", thr, 0);
        v_tgt = 6'd20;
        tick(2);
    endtask

    task automatic t_modulation;
        vf_en = 1'b0;
        hot = 1'b1;
        for (int i = 0; i < 20; i++) begin
            tick(1);
            chk("R8", "gating pattern", clk_en, ((i % 10) >= 4) ? 1 : 0);
        end
        chk("R8", "throttle in gating", thr, 1);
        chk("R8", "ratio nominal in gating", ratio, 9);
        chk("R8", "vid nominal in gating", vid, 16);
        tick(2);
        hot = 1'b0;
        tick(1);
        chk("R9", "clock back on", clk_en, 1);
        chk("R9", "throttle off", thr, 0);
        vf_en = 1'b1;
        tick(2);
    endtask

    task automatic t_disabled;
        vf_en = 1'b0;
        mod_en = 1'b0;
        hot = 1'b1;
        tick(8);
        chk("R10", "no throttle", thr, 0);
        chk("R10", "clock on", clk_en, 1);
        chk("R10", "ratio nominal", ratio, 9);
        chk("R10", "vid nominal", vid, 16);
        hot = 1'b0;
        vf_en = 1'b1;
        mod_en = 1'b1;
        tick(2);
    endtask

    task automatic t_mode_change;
        hot = 1'b1;
        tick(1);
        vf_en = 1'b0;
        tick(4);
        chk("R11", "walk continues", vid, 17);
        chk("R11", "clock not gated", clk_en, 1);
        chk("R11", "ratio still low", ratio, 6);
        vf_en = 1'b1;
        hot = 1'b0;
        tick(12);
        chk("R11", "returned to idle", thr, 0);
        chk("R11", "ratio nominal", ratio, 9);
        tick(2);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_vf_full();
        t_reverse();
        t_clamp();
        t_modulation();
        t_disabled();
        t_mode_change();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule